// File: doc/BRIEF.md
# Four-Channel Management Interface Slave

This block is the management-port target of a device that carries four independent physical channels. A management master clocks serial frames into it on the management clock. Each frame starts with a run of ones, followed by a two-bit start pattern and a two-bit opcode. The header carries a 5-bit device address and a 5-bit register index, then a two-bit turnaround and a 16-bit data word. The block samples the data line on the rising clock edge. It changes its own output only on the falling edge, and it drives the line only while returning read data, through an output-enable pin.

The device address splits into two parts. The upper three bits must match the chip-ID strap pins, and the lower two bits name the channel. One chip therefore answers at four addresses. The per-channel register keeps one copy for each channel, and the channel number picks the copy. The common register holds a single value that applies to every channel. The shared register gives each channel its own group of bits. Both the common and the shared register are reached only at channel number 0. Every register value is also presented on output pins so that the channel logic can use it. All other register indices read back as zero.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is recognised only after at least PRE_MIN consecutive ones followed by the start pattern 0 then 1. A frame with a shorter run of ones causes no register change and no driving of the line.
- R2: Opcode bits 1,0 mean read and 0,1 mean write. Opcodes 0,0 and 1,1 abandon the frame with no write and no driving, and the slave then waits for a fresh run of ones.
- R3: The first three address bits on the wire are compared with `chip_id`. On a mismatch, `mdio_oe` stays low for the whole frame and no register changes.
- R4: For a matching read, `mdio_oe` is low during the first turnaround bit. The slave drives 0 during the second turnaround bit and then the 16 data bits, most significant bit first. Every change happens at a falling `mdc` edge, and `mdio_oe` returns low after the last data bit.
- R5: Register index 0x10 is per-channel. Channel number c (the last two address bits) reads and writes copy c, which is presented on `rep_q[16c+15:16c]`.
- R6: Register index 0x11 is common. A write through channel 0 sets `com_q`, and a read through channel 0 returns it.
- R7: An access to index 0x11 or 0x12 with a nonzero channel number is ignored. A write leaves the register unchanged, and a read leaves `mdio_oe` low.
- R8: Register index 0x12 is shared and is written and read through channel 0. Bits [4c+3:4c] of `shr_q` belong to channel c.
- R9: Any other register index reads back as 0x0000, driven as a normal read, and ignores writes.
- R10: A write takes effect at the rising edge that samples its 16th data bit, and only if its turnaround bits were 1 then 0. Otherwise the write is dropped.
- R11: While `rst_n` is low, all registers clear to zero and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; input sampled on rising edge, output updated on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | 3 | Strapped chip identifier, compared with upper address bits |
| mdio_in | input | 1 | Sampled level of the management data line |
| mdio_out | output | 1 | Value the slave places on the data line |
| mdio_oe | output | 1 | High while the slave drives the data line |
| rep_q | output | 64 | Per-channel register copies, channel c at bits [16c+15:16c] |
| com_q | output | 16 | Common register value |
| shr_q | output | 16 | Shared register, channel c owns bits [4c+3:4c] |

## Verification
The bench builds the block with its defaults: four channels, a minimum run of 32 ones, and the three register indices 0x10, 0x11 and 0x12. The strap pins are tied to 101. With four channels, every channel number reaches its own copy of the per-channel register, and the bench can show that distinct values stay apart. With a 32-bit threshold, a 20-bit run of ones is a real short-preamble case. The nonzero strap lets a neighbouring chip ID be used to test address mismatch.

// File: rtl/mdio_slave_pkg.sv
package mdio_slave_pkg;
  localparam int PHY_W    = 5;
  localparam int REG_W    = 5;
  localparam int FRAME_DW = 16;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [2:0] {
    M_PRE,
    M_ST,
    M_OP,
    M_HDR,
    M_TA,
    M_DAT
  } mframe_e;
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_slave_pkg::*;
#(
  parameter int PRE_MIN = 32
) (
  input  logic                mdc,
  input  logic                rst_n,
  input  logic                mdio_in,
  output mframe_e             st,
  output logic [3:0]          cnt,
  output logic                is_rd,
  output logic [PHY_W-1:0]    phy,
  output logic [REG_W-1:0]    rg,
  output logic                wr_en,
  output logic [FRAME_DW-1:0] wr_data
);
  localparam int PW = $clog2(PRE_MIN + 1);
  localparam logic [PW-1:0] PRE_LIM = PW'(PRE_MIN);

  mframe_e             st_q;
  logic [3:0]          cnt_q;
  logic [PW-1:0]       pre_q;
  logic [FRAME_DW-2:0] sh_q;
  logic                rd_q;
  logic [PHY_W-1:0]    phy_q;
  logic [REG_W-1:0]    rg_q;

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= M_PRE;
      cnt_q <= '0;
      pre_q <= '0;
      sh_q  <= '0;
      rd_q  <= 1'b0;
      phy_q <= '0;
      rg_q  <= '0;
    end else begin
      sh_q <= {sh_q[FRAME_DW-3:0], mdio_in};
      if (st_q != M_PRE) pre_q <= '0;
      case (st_q)
        M_PRE: begin
          if (mdio_in) begin
            if (pre_q != PRE_LIM) pre_q <= pre_q + 1'b1;
          end else begin
            if (pre_q == PRE_LIM) st_q <= M_ST;
            pre_q <= '0;
          end
        end
        M_ST: begin
          st_q  <= mdio_in ? M_OP : M_PRE;
          cnt_q <= '0;
        end
        M_OP: begin
          if (cnt_q == 4'd0) begin
            cnt_q <= 4'd1;
          end else begin
            cnt_q <= '0;
            if ({sh_q[0], mdio_in} == OP_RD) begin
              rd_q <= 1'b1;
              st_q <= M_HDR;
            end else if ({sh_q[0], mdio_in} == OP_WR) begin
              rd_q <= 1'b0;
              st_q <= M_HDR;
            end else begin
              st_q <= M_PRE;
            end
          end
        end
        M_HDR: begin
          if (cnt_q == 4'd9) begin
            phy_q <= sh_q[8:4];
            rg_q  <= {sh_q[3:0], mdio_in};
            st_q  <= M_TA;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        M_TA: begin
          if (cnt_q == 4'd0) begin
            cnt_q <= 4'd1;
          end else begin
            cnt_q <= '0;
            if (!rd_q && !(sh_q[0] && !mdio_in)) st_q <= M_PRE;
            else                                 st_q <= M_DAT;
          end
        end
        M_DAT: begin
          if (cnt_q == 4'd15) begin
            st_q  <= M_PRE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 4'd1;
          end
        end
        default: st_q <= M_PRE;
      endcase
    end
  end

  assign st      = st_q;
  assign cnt     = cnt_q;
  assign is_rd   = rd_q;
  assign phy     = phy_q;
  assign rg      = rg_q;
  assign wr_en   = (st_q == M_DAT) && (cnt_q == 4'd15) && !rd_q;
  assign wr_data = {sh_q, mdio_in};
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_slave_pkg::*;
#(
  parameter int N_CH = 4,
  parameter logic [REG_W-1:0] REP_ADDR = 5'h10,
  parameter logic [REG_W-1:0] COM_ADDR = 5'h11,
  parameter logic [REG_W-1:0] SHR_ADDR = 5'h12,
  localparam int CH_W = $clog2(N_CH),
  localparam int ID_W = PHY_W - CH_W
) (
  input  logic                     mdc,
  input  logic                     rst_n,
  input  logic [ID_W-1:0]          chip_id,
  input  logic [PHY_W-1:0]         phy,
  input  logic [REG_W-1:0]         rg,
  input  logic                     wr_en,
  input  logic [FRAME_DW-1:0]      wr_data,
  output logic [FRAME_DW-1:0]      rd_data,
  output logic                     acc_ok,
  output logic [N_CH*FRAME_DW-1:0] rep_q,
  output logic [FRAME_DW-1:0]      com_q,
  output logic [FRAME_DW-1:0]      shr_q
);
  logic [CH_W-1:0]     ch;
  logic                id_hit, glob;
  logic [FRAME_DW-1:0] rep_r [N_CH];
  logic [FRAME_DW-1:0] com_r, shr_r;

  assign ch     = phy[CH_W-1:0];
  assign id_hit = (phy[PHY_W-1:CH_W] == chip_id);
  assign glob   = (rg == COM_ADDR) || (rg == SHR_ADDR);
  assign acc_ok = id_hit && !(glob && (ch != '0));

  for (genvar c = 0; c < N_CH; c++) begin : g_rep
    always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n)
        rep_r[c] <= '0;
      else if (wr_en && acc_ok && rg == REP_ADDR && ch == CH_W'(c))
        rep_r[c] <= wr_data;
    end
    assign rep_q[c*FRAME_DW +: FRAME_DW] = rep_r[c];
  end

  always_ff @(posedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      com_r <= '0;
      shr_r <= '0;
    end else if (wr_en && acc_ok) begin
      if (rg == COM_ADDR) com_r <= wr_data;
      if (rg == SHR_ADDR) shr_r <= wr_data;
    end
  end

  always_comb begin
    if (rg == REP_ADDR)      rd_data = rep_r[ch];
    else if (rg == COM_ADDR) rd_data = com_r;
    else if (rg == SHR_ADDR) rd_data = shr_r;
    else                     rd_data = '0;
  end

  assign com_q = com_r;
  assign shr_q = shr_r;
endmodule

// File: rtl/mdio_tx_drv.sv
module mdio_tx_drv
  import mdio_slave_pkg::*;
(
  input  logic                mdc,
  input  logic                rst_n,
  input  mframe_e             st,
  input  logic [3:0]          cnt,
  input  logic                is_rd,
  input  logic                acc_ok,
  input  logic [FRAME_DW-1:0] rd_data,
  output logic                mdio_out,
  output logic                mdio_oe
);
  logic drv;
  assign drv = is_rd && acc_ok;

  always_ff @(negedge mdc or negedge rst_n) begin
    if (!rst_n) begin
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end else if (drv && st == M_TA && cnt == 4'd1) begin
      mdio_oe  <= 1'b1;
      mdio_out <= 1'b0;
    end else if (drv && st == M_DAT) begin
      mdio_oe  <= 1'b1;
      mdio_out <= rd_data[4'd15 - cnt];
    end else begin
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slave_pkg::*;
#(
  parameter int N_CH    = 4,
  parameter int PRE_MIN = 32,
  parameter logic [REG_W-1:0] REP_ADDR = 5'h10,
  parameter logic [REG_W-1:0] COM_ADDR = 5'h11,
  parameter logic [REG_W-1:0] SHR_ADDR = 5'h12,
  localparam int CH_W = $clog2(N_CH),
  localparam int ID_W = PHY_W - CH_W
) (
  input  logic                     mdc,
  input  logic                     rst_n,
  input  logic [ID_W-1:0]          chip_id,
  input  logic                     mdio_in,
  output logic                     mdio_out,
  output logic                     mdio_oe,
  output logic [N_CH*FRAME_DW-1:0] rep_q,
  output logic [FRAME_DW-1:0]      com_q,
  output logic [FRAME_DW-1:0]      shr_q
);
  mframe_e             st;
  logic [3:0]          cnt;
  logic                is_rd, wr_en, acc_ok;
  logic [PHY_W-1:0]    phy;
  logic [REG_W-1:0]    rg;
  logic [FRAME_DW-1:0] wr_data, rd_data;

  mdio_frame_rx #(.PRE_MIN(PRE_MIN)) u_rx (
    .mdc(mdc), .rst_n(rst_n), .mdio_in(mdio_in),
    .st(st), .cnt(cnt), .is_rd(is_rd), .phy(phy), .rg(rg),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  mdio_reg_bank #(
    .N_CH(N_CH), .REP_ADDR(REP_ADDR), .COM_ADDR(COM_ADDR), .SHR_ADDR(SHR_ADDR)
  ) u_bank (
    .mdc(mdc), .rst_n(rst_n), .chip_id(chip_id), .phy(phy), .rg(rg),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .acc_ok(acc_ok),
    .rep_q(rep_q), .com_q(com_q), .shr_q(shr_q)
  );

  mdio_tx_drv u_tx (
    .mdc(mdc), .rst_n(rst_n), .st(st), .cnt(cnt), .is_rd(is_rd),
    .acc_ok(acc_ok), .rd_data(rd_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk
  import mdio_slave_pkg::*;
#(
  parameter logic [REG_W-1:0] COM_ADDR = 5'h11,
  parameter logic [REG_W-1:0] SHR_ADDR = 5'h12
) (
  input logic                mdc,
  input logic                rst_n,
  input logic [2:0]          chip_id,
  input mframe_e             st,
  input logic [3:0]          cnt,
  input logic                is_rd,
  input logic [PHY_W-1:0]    phy,
  input logic [REG_W-1:0]    rg,
  input logic                wr_en,
  input logic                mdio_out,
  input logic                mdio_oe,
  input logic [FRAME_DW-1:0] com_q
);
  assert_oe_read_phase_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> (is_rd && (st == M_DAT || (st == M_TA && cnt == 4'd1))));

  assert_ta_low_R4: assert property (@(posedge mdc) disable iff (!rst_n)
    (mdio_oe && st == M_TA) |-> !mdio_out);

  assert_id_miss_quiet_R3: assert property (@(posedge mdc) disable iff (!rst_n)
    (st == M_DAT && phy[4:2] != chip_id) |-> !mdio_oe);

  assert_glob_nonzero_quiet_R7: assert property (@(posedge mdc) disable iff (!rst_n)
    (st == M_DAT && (rg == COM_ADDR || rg == SHR_ADDR) && phy[1:0] != 2'b00) |-> !mdio_oe);

  assert_com_hold_R6: assert property (@(posedge mdc) disable iff (!rst_n)
    !wr_en |=> $stable(com_q));
endmodule

bind mdio_mgmt_slave mdio_mgmt_chk #(.COM_ADDR(COM_ADDR), .SHR_ADDR(SHR_ADDR)) u_chk (
  .mdc(mdc), .rst_n(rst_n), .chip_id(chip_id), .st(st), .cnt(cnt),
  .is_rd(is_rd), .phy(phy), .rg(rg), .wr_en(wr_en),
  .mdio_out(mdio_out), .mdio_oe(mdio_oe), .com_q(com_q)
);

// File: tb/sim_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  chip_id = 3'b101;
  logic        m_bit = 1'b1;
  logic        mdio_in, mdio_out, mdio_oe;
  logic [63:0] rep_q;
  logic [15:0] com_q, shr_q;
  int total = 0, bad = 0;

  always #4 clk = ~clk;
  assign mdio_in = mdio_oe ? mdio_out : m_bit;

  mdio_mgmt_slave u0 (
    .mdc(clk), .rst_n(rst_n), .chip_id(chip_id), .mdio_in(mdio_in),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .rep_q(rep_q), .com_q(com_q), .shr_q(shr_q)
  );

  logic        f_any_oe, f_ta1_oe, f_ta2_oe, f_ta2_val, f_dat_oe;
  logic [15:0] f_rd;

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    m_bit = b;
    #1;
    if (mdio_oe) f_any_oe = 1'b1;
  endtask

  task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [1:0] ta, input logic [15:0] wd);
    f_any_oe = 0; f_ta1_oe = 0; f_ta2_oe = 0; f_ta2_val = 1; f_dat_oe = 1; f_rd = '0;
    for (int i = 0; i < pre; i++) send_bit(1'b1);
    send_bit(1'b0); send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(op[i]);
    for (int i = 4; i >= 0; i--) send_bit(phy[i]);
    for (int i = 4; i >= 0; i--) send_bit(rg[i]);
    if (op == 2'b10) begin
      send_bit(1'b1); f_ta1_oe = mdio_oe;
      send_bit(1'b1); f_ta2_oe = mdio_oe; f_ta2_val = mdio_out;
      for (int i = 15; i >= 0; i--) begin
        send_bit(1'b1);
        f_rd[i] = mdio_in;
        if (!mdio_oe) f_dat_oe = 1'b0;
      end
    end else begin
      send_bit(ta[1]); send_bit(ta[0]);
      for (int i = 15; i >= 0; i--) send_bit(wd[i]);
    end
    send_bit(1'b1);
    if (mdio_oe) f_any_oe = 1'b1;
  endtask

  // {op, ch, reg, wdata, expected, expect_drive}
  localparam int NV = 15;
  localparam logic [41:0] VEC [NV] = '{
    {2'b01, 2'd0, 5'h10, 16'hA001, 16'h0000, 1'b0},
    {2'b01, 2'd1, 5'h10, 16'hB012, 16'h0000, 1'b0},
    {2'b01, 2'd2, 5'h10, 16'hC123, 16'h0000, 1'b0},
    {2'b01, 2'd3, 5'h10, 16'hD234, 16'h0000, 1'b0},
    {2'b10, 2'd0, 5'h10, 16'h0000, 16'hA001, 1'b1},
    {2'b10, 2'd1, 5'h10, 16'h0000, 16'hB012, 1'b1},
    {2'b10, 2'd2, 5'h10, 16'h0000, 16'hC123, 1'b1},
    {2'b10, 2'd3, 5'h10, 16'h0000, 16'hD234, 1'b1},
    {2'b01, 2'd0, 5'h11, 16'h5A5A, 16'h0000, 1'b0},
    {2'b10, 2'd0, 5'h11, 16'h0000, 16'h5A5A, 1'b1},
    {2'b01, 2'd0, 5'h12, 16'h1234, 16'h0000, 1'b0},
    {2'b10, 2'd0, 5'h12, 16'h0000, 16'h1234, 1'b1},
    {2'b01, 2'd0, 5'h05, 16'hFFFF, 16'h0000, 1'b0},
    {2'b10, 2'd0, 5'h05, 16'h0000, 16'h0000, 1'b1},
    {2'b10, 2'd2, 5'h11, 16'h0000, 16'h0000, 1'b0}
  };

  initial begin
    #1600000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!mdio_oe && rep_q == '0 && com_q == '0 && shr_q == '0, "R11 reset state",
        {rep_q[15:0], com_q, shr_q, 15'b0, mdio_oe}, 64'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [41:0] e;
      e = VEC[v];
      frame(32, e[41:40], {3'b101, e[39:38]}, e[37:33], 2'b10, e[32:17]);
      if (e[0]) begin
        chk(f_rd == e[16:1] && f_dat_oe, "R4/R5/R6/R8/R9 read data", {48'b0, f_rd}, {48'b0, e[16:1]});
        chk(!f_ta1_oe && f_ta2_oe && !f_ta2_val, "R4 turnaround",
            {61'b0, f_ta1_oe, f_ta2_oe, f_ta2_val}, 64'h2);
      end else begin
        chk(!f_any_oe, "R7 line released", {63'b0, f_any_oe}, 64'h0);
      end
    end

    chk(rep_q[47:32] == 16'hC123, "R5 rep_q channel 2", {48'b0, rep_q[47:32]}, 64'hC123);
    chk(shr_q[7:4] == 4'h3, "R8 channel 1 nibble", {60'b0, shr_q[7:4]}, 64'h3);

    frame(32, 2'b01, 5'b10101, 5'h11, 2'b10, 16'hFFFF);
    chk(com_q == 16'h5A5A, "R7 common via channel 1", {48'b0, com_q}, 64'h5A5A);
    frame(32, 2'b01, 5'b10111, 5'h12, 2'b10, 16'hFFFF);
    chk(shr_q == 16'h1234, "R7 shared via channel 3", {48'b0, shr_q}, 64'h1234);

    frame(32, 2'b10, 5'b10001, 5'h10, 2'b10, 16'h0);
    chk(!f_any_oe, "R3 id mismatch read", {63'b0, f_any_oe}, 64'h0);
    frame(32, 2'b01, 5'b01100, 5'h10, 2'b10, 16'h0BAD);
    chk(rep_q[15:0] == 16'hA001, "R3 id mismatch write", {48'b0, rep_q[15:0]}, 64'hA001);

    frame(20, 2'b01, 5'b10100, 5'h10, 2'b10, 16'h0BAD);
    chk(rep_q[15:0] == 16'hA001, "R1 short preamble", {48'b0, rep_q[15:0]}, 64'hA001);
    frame(32, 2'b11, 5'b10100, 5'h10, 2'b10, 16'h0BAD);
    chk(rep_q[15:0] == 16'hA001, "R2 opcode 11", {48'b0, rep_q[15:0]}, 64'hA001);
    frame(32, 2'b00, 5'b10100, 5'h10, 2'b10, 16'h0BAD);
    chk(rep_q[15:0] == 16'hA001 && !f_any_oe, "R2 opcode 00", {48'b0, rep_q[15:0]}, 64'hA001);
    frame(32, 2'b01, 5'b10100, 5'h10, 2'b11, 16'h0BAD);
    chk(rep_q[15:0] == 16'hA001, "R10 bad turnaround", {48'b0, rep_q[15:0]}, 64'hA001);
    frame(32, 2'b01, 5'b10100, 5'h10, 2'b10, 16'h7E81);
    chk(rep_q[15:0] == 16'h7E81, "R10 good write", {48'b0, rep_q[15:0]}, 64'h7E81);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    chk(rep_q == '0 && com_q == '0 && shr_q == '0 && !mdio_oe, "R11 mid-run reset",
        {rep_q[15:0], com_q, shr_q, 16'b0}, 64'h0);
    rst_n = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule